// File: doc/BRIEF.md
# Multiplexed-Bus Pseudo-SRAM Host Controller

This block sits on the host side of a pseudo-SRAM that shares its sixteen data lines with the low address bits. It takes one word request at a time from a valid/ready interface and turns it into the two-phase bus sequence the memory expects. In the first phase chip select falls, the address goes out on the shared lines and on two dedicated upper pins, and an active-low address strobe is pulsed. In the second phase the controller either releases the shared lines and raises the output enable for a read, or drives the write data and pulses write enable. Byte lane enables come from the request's two-bit mask.

After reset the controller waits out a power-up hold with chip select high before it shows ready. Every timing value is a parameter counted in clock cycles. The defaults are rounded up from nanosecond figures at the chosen clock period. The shared lines leave the block as a value, a drive enable and a return path, so the pad's three-state buffer sits outside it. A read reports its word on a one-cycle valid strobe.

Top module: `psram_mux_ctrl`

## Requirements
- R1: From reset release, `cs_n` stays high and `req_ready` stays low for `PWRUP_CYC` clock cycles. `req_ready` rises on the next cycle. A request presented during this wait starts no bus activity.
- R2: An accepted request opens with `SETUP_CYC` cycles in which `cs_n` is low and `avd_n` is high. During these cycles `adq_out` carries address bits 15:0 with `adq_oe` high, and `addr_hi` carries address bits 17:16.
- R3: `avd_n` then stays low for exactly `AVD_LOW_CYC` cycles, which is fewer than `AVD_MAX_CYC`. The address stays driven and unchanged on `adq_out` and `addr_hi` for `AVD_HOLD_CYC` further cycles after `avd_n` rises.
- R4: In a read, `adq_oe` is low and `oe_n` is low for `RD_ACC_CYC` cycles, and `be_n` equals the inverted mask (bit 0 is the low byte, bit 1 is the high byte). `adq_in` is captured at the end of the last such cycle. It appears on `rd_data` with `rd_valid` high for exactly one cycle, the first cycle after `oe_n` rises.
- R5: In a write, `adq_out` carries the write data with `adq_oe` high. `we_n` is low for exactly `WR_LOW_CYC` cycles with `be_n` equal to the inverted mask, and `oe_n` stays high.
- R6: After `we_n` rises, the write data stays driven and unchanged for one more cycle, with `cs_n` already high.
- R7: After `oe_n` rises at the end of a read, `adq_oe` stays low for `BUS_HZ_CYC` cycles, with `cs_n` high.
- R8: Between two accesses `cs_n` is high for at least one cycle, so each access starts with a new address phase.
- R9: `req_ready` is high only while no access is in flight. A request held valid during an access is not taken until the access completes, and the access in flight keeps the address and data it captured.
- R10: Paired with a memory that drives the shared lines while `oe_n` is low and for up to two cycles after, the controller never drives them in the same cycle. Masked writes change only the enabled bytes, as read-after-write data shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes to access, bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | One-cycle strobe, read data present |
| rd_data | output | 16 | Captured read word |
| cs_n | output | 1 | Chip select, active low |
| avd_n | output | 1 | Address strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| be_n | output | 2 | Byte lane enables, active low, bit 0 low byte |
| addr_hi | output | 2 | Upper address pins |
| adq_out | output | 16 | Value driven onto the shared lines |
| adq_oe | output | 1 | Drive enable for the shared lines |
| adq_in | input | 16 | Value read from the shared lines |

## Verification
Two things can land in the same cycle. The end of one access's bus release can meet the start of the next access's address drive, and a request held valid can meet the single idle cycle in which it is allowed to be taken. The bench issues requests back to back and holds valid high through whole accesses. A paired memory model keeps driving the lines for two cycles after the output enable rises, and a monitor that samples away from both clock edges flags any cycle in which both sides drive. The per-cycle control checks then confirm the idle cycle separates the accesses and that the access in flight kept its own address.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;

  // Bus sequencing phases
  typedef enum logic [3:0] {
    PH_PWRUP  = 4'd0,
    PH_IDLE   = 4'd1,
    PH_SETUP  = 4'd2,
    PH_AVD    = 4'd3,
    PH_AHOLD  = 4'd4,
    PH_RDATA  = 4'd5,
    PH_RREC   = 4'd6,
    PH_WDATA  = 4'd7,
    PH_WEND   = 4'd8
  } psram_phase_e;

  // Round a picosecond figure up to whole clock cycles, never below one.
  function automatic int ps_to_cycles(input longint unsigned dur_ps,
                                      input int unsigned clk_ps);
    longint unsigned c;
    c = (dur_ps + clk_ps - 1) / clk_ps;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  // Round down, for upper limits.
  function automatic int ps_to_cycles_floor(input longint unsigned dur_ps,
                                            input int unsigned clk_ps);
    return int'(dur_ps / clk_ps);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Chip select is asserted in these phases.
  function automatic logic phase_selects(input psram_phase_e ph);
    return (ph == PH_SETUP) || (ph == PH_AVD) || (ph == PH_AHOLD) ||
           (ph == PH_RDATA) || (ph == PH_WDATA);
  endfunction

  // Address is presented on the shared lines in these phases.
  function automatic logic phase_addr(input psram_phase_e ph);
    return (ph == PH_SETUP) || (ph == PH_AVD) || (ph == PH_AHOLD);
  endfunction

endpackage

// File: rtl/psram_pwrup_wait.sv
`timescale 1ns/1ps
module psram_pwrup_wait #(
  parameter int WAIT_CYC = 40000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(WAIT_CYC + 1) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/psram_phase_timer.sv
`timescale 1ns/1ps
module psram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (!expired)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/psram_bus_fsm.sv
`timescale 1ns/1ps
module psram_bus_fsm
  import psram_pkg::*;
#(
  parameter int SETUP_CYC    = 2,
  parameter int AVD_LOW_CYC  = 3,
  parameter int AVD_HOLD_CYC = 1,
  parameter int RD_ACC_CYC   = 14,
  parameter int BUS_HZ_CYC   = 3,
  parameter int WR_LOW_CYC   = 9,
  parameter int WR_END_CYC   = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_done,
  input  logic         req_fire,
  input  logic         cur_is_write,
  output psram_phase_e phase,
  output logic         phase_last
);
  localparam int MAXLEN = max_of(max_of(max_of(SETUP_CYC, AVD_LOW_CYC),
                                        max_of(AVD_HOLD_CYC, RD_ACC_CYC)),
                                 max_of(max_of(BUS_HZ_CYC, WR_LOW_CYC),
                                        WR_END_CYC));
  localparam int TW = $clog2(MAXLEN + 1);

  psram_phase_e phase_q, phase_d;
  logic         tmr_load;
  logic [TW-1:0] tmr_val;
  logic         tmr_expired;

  function automatic logic [TW-1:0] phase_len_m1(input psram_phase_e ph);
    int len;
    case (ph)
      PH_SETUP: len = SETUP_CYC;
      PH_AVD:   len = AVD_LOW_CYC;
      PH_AHOLD: len = AVD_HOLD_CYC;
      PH_RDATA: len = RD_ACC_CYC;
      PH_RREC:  len = BUS_HZ_CYC;
      PH_WDATA: len = WR_LOW_CYC;
      PH_WEND:  len = WR_END_CYC;
      default:  len = 1;
    endcase
    return TW'(len - 1);
  endfunction

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_PWRUP: if (pwr_done)    phase_d = PH_IDLE;
      PH_IDLE:  if (req_fire)    phase_d = PH_SETUP;
      PH_SETUP: if (tmr_expired) phase_d = PH_AVD;
      PH_AVD:   if (tmr_expired) phase_d = PH_AHOLD;
      PH_AHOLD: if (tmr_expired) phase_d = cur_is_write ? PH_WDATA : PH_RDATA;
      PH_RDATA: if (tmr_expired) phase_d = PH_RREC;
      PH_RREC:  if (tmr_expired) phase_d = PH_IDLE;
      PH_WDATA: if (tmr_expired) phase_d = PH_WEND;
      PH_WEND:  if (tmr_expired) phase_d = PH_IDLE;
      default:                   phase_d = PH_IDLE;
    endcase
  end

  assign tmr_load = (phase_d != phase_q);
  assign tmr_val  = phase_len_m1(phase_d);

  psram_phase_timer #(.W(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_PWRUP;
    else        phase_q <= phase_d;
  end

  assign phase      = phase_q;
  assign phase_last = tmr_expired;
endmodule

// File: rtl/psram_mux_ctrl.sv
`timescale 1ns/1ps
module psram_mux_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int CLK_PS       = 5000,
  parameter int PWRUP_CYC    = ps_to_cycles(64'd200_000_000, CLK_PS),
  parameter int SETUP_CYC    = ps_to_cycles(64'd7_000, CLK_PS),
  parameter int AVD_LOW_CYC  = ps_to_cycles(64'd15_000, CLK_PS),
  parameter int AVD_MAX_CYC  = ps_to_cycles_floor(64'd1_000_000, CLK_PS),
  parameter int AVD_HOLD_CYC = ps_to_cycles(64'd5_000, CLK_PS),
  parameter int RD_ACC_CYC   = ps_to_cycles(64'd70_000, CLK_PS),
  parameter int BUS_HZ_CYC   = ps_to_cycles(64'd15_000, CLK_PS),
  parameter int WR_LOW_CYC   = ps_to_cycles(64'd45_000, CLK_PS),
  localparam int HI_W = ADDR_W - DATA_W,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              cs_n,
  output logic              avd_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [BE_W-1:0]   be_n,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] adq_out,
  output logic              adq_oe,
  input  logic [DATA_W-1:0] adq_in
);

  // Named internal events, also used by the bound checker
  logic         pwr_done;
  logic         req_fire;
  psram_phase_e phase;
  logic         phase_last;
  logic         addr_phase;
  logic         rd_phase;
  logic         wr_phase;
  logic         rd_sample;

  // Captured request
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   mask_q;

  psram_pwrup_wait #(.WAIT_CYC(PWRUP_CYC)) u_pwr (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (pwr_done)
  );

  psram_bus_fsm #(
    .SETUP_CYC    (SETUP_CYC),
    .AVD_LOW_CYC  (AVD_LOW_CYC),
    .AVD_HOLD_CYC (AVD_HOLD_CYC),
    .RD_ACC_CYC   (RD_ACC_CYC),
    .BUS_HZ_CYC   (BUS_HZ_CYC),
    .WR_LOW_CYC   (WR_LOW_CYC),
    .WR_END_CYC   (1)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_done     (pwr_done),
    .req_fire     (req_fire),
    .cur_is_write (wr_q),
    .phase        (phase),
    .phase_last   (phase_last)
  );

  assign req_ready  = (phase == PH_IDLE);
  assign req_fire   = req_valid && req_ready;
  assign addr_phase = phase_addr(phase);
  assign rd_phase   = (phase == PH_RDATA);
  assign wr_phase   = (phase == PH_WDATA);
  assign rd_sample  = rd_phase && phase_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (req_fire) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  // Bus controls decoded from the registered phase
  assign cs_n    = !phase_selects(phase);
  assign avd_n   = (phase != PH_AVD);
  assign oe_n    = !rd_phase;
  assign we_n    = !wr_phase;
  assign adq_oe  = addr_phase || wr_phase || (phase == PH_WEND);
  assign adq_out = addr_phase ? addr_q[DATA_W-1:0] : wdata_q;
  assign addr_hi = addr_q[ADDR_W-1:DATA_W];

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign be_n[g] = !((rd_phase || wr_phase) && mask_q[g]);
  end

  // Read capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_sample;
      if (rd_sample) rd_data <= adq_in;
    end
  end

endmodule

// File: rtl/psram_mux_ctrl_chk.sv
`timescale 1ns/1ps
module psram_mux_ctrl_chk #(
  parameter int DATA_W       = 16,
  parameter int HI_W         = 2,
  parameter int AVD_LOW_CYC  = 3,
  parameter int AVD_MAX_CYC  = 200,
  parameter int BUS_HZ_CYC   = 3,
  parameter int WR_LOW_CYC   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_done,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              cs_n,
  input logic              avd_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [HI_W-1:0]   addr_hi,
  input logic [DATA_W-1:0] adq_out,
  input logic              adq_oe
);
  localparam int CW = $clog2(AVD_MAX_CYC + WR_LOW_CYC + BUS_HZ_CYC + 2) + 1;

  logic [CW-1:0] avd_lo_cnt, we_lo_cnt, since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avd_lo_cnt <= '0;
      we_lo_cnt  <= '0;
      since_oe   <= CW'(BUS_HZ_CYC);
    end else begin
      avd_lo_cnt <= !avd_n ? avd_lo_cnt + 1'b1 : '0;
      we_lo_cnt  <= !we_n  ? we_lo_cnt + 1'b1  : '0;
      if (!oe_n)                         since_oe <= '0;
      else if (since_oe < CW'(BUS_HZ_CYC)) since_oe <= since_oe + 1'b1;
    end
  end

  AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_done |-> (cs_n && !req_ready)); // R1
  AST_AVD_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !avd_n |-> (!cs_n && adq_oe)); // R2
  AST_AVD_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avd_n) |-> (avd_lo_cnt == CW'(AVD_LOW_CYC))); // R3
  AST_AVD_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    !avd_n |-> (avd_lo_cnt < CW'(AVD_MAX_CYC))); // R3
  AST_ADDR_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avd_n) |-> (adq_oe && $stable(adq_out) && $stable(addr_hi))); // R3
  AST_READ_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!adq_oe && !cs_n && we_n)); // R4
  AST_RDVALID_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (oe_n && $past(!oe_n))); // R4
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (adq_oe && !cs_n && oe_n)); // R5
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_lo_cnt == CW'(WR_LOW_CYC))); // R5
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (adq_oe && $stable(adq_out) && cs_n)); // R6
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    adq_oe |-> (since_oe >= CW'(BUS_HZ_CYC))); // R7
  AST_CS_FALL_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(req_ready && req_valid)); // R8
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && oe_n && we_n && !adq_oe)); // R9
endmodule

bind psram_mux_ctrl psram_mux_ctrl_chk #(
  .DATA_W      (DATA_W),
  .HI_W        (HI_W),
  .AVD_LOW_CYC (AVD_LOW_CYC),
  .AVD_MAX_CYC (AVD_MAX_CYC),
  .BUS_HZ_CYC  (BUS_HZ_CYC),
  .WR_LOW_CYC  (WR_LOW_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_done  (pwr_done),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .cs_n      (cs_n),
  .avd_n     (avd_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .addr_hi   (addr_hi),
  .adq_out   (adq_out),
  .adq_oe    (adq_oe)
);

// File: tb/psram_mux_ctrl_tb.sv
`timescale 1ns/1ps
module psram_mux_ctrl_tb;
  localparam int PWR   = 200;
  localparam int CLKPS = 5000;

  function automatic int up_cyc(input int ps);
    int c = ps / CLKPS;
    if (c * CLKPS < ps) c = c + 1;
    return c;
  endfunction

  localparam int T_SET = up_cyc(7000);
  localparam int T_AVD = up_cyc(15000);
  localparam int T_AH  = up_cyc(5000);
  localparam int T_RD  = up_cyc(70000);
  localparam int T_HZ  = up_cyc(15000);
  localparam int T_WR  = up_cyc(45000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rd_valid, cs_n, avd_n, oe_n, we_n, adq_oe;
  logic [15:0] rd_data, adq_out, adq_in;
  logic [1:0]  be_n, addr_hi;

  int n_chk = 0;
  int n_err = 0;
  int n_clash = 0;

  always #2.5 clk = ~clk;

  psram_mux_ctrl #(.PWRUP_CYC(PWR)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .cs_n(cs_n), .avd_n(avd_n), .oe_n(oe_n), .we_n(we_n), .be_n(be_n),
    .addr_hi(addr_hi), .adq_out(adq_out), .adq_oe(adq_oe), .adq_in(adq_in)
  );

  // ---------------- behavioural multiplexed memory ----------------
  logic [15:0] mdl_mem [logic [17:0]];
  logic [17:0] mdl_addr = '0;
  int          mdl_tail = 0;
  logic        mdl_drv;

  function automatic logic [15:0] lanes(input logic [15:0] w, input logic [1:0] en);
    return {en[1] ? w[15:8] : 8'h00, en[0] ? w[7:0] : 8'h00};
  endfunction

  function automatic logic [15:0] mdl_word(input logic [17:0] a);
    return mdl_mem.exists(a) ? mdl_mem[a] : 16'h0000;
  endfunction

  assign mdl_drv = (!cs_n && !oe_n) || (mdl_tail > 0);
  assign adq_in  = mdl_drv ? lanes(mdl_word(mdl_addr), ~be_n) : 16'h0000;

  always @(negedge clk) begin
    if (!cs_n && !avd_n) mdl_addr <= {addr_hi, adq_out};
    if (!cs_n && !we_n) begin
      logic [15:0] w;
      w = mdl_word(mdl_addr);
      if (!be_n[0]) w[7:0]  = adq_out[7:0];
      if (!be_n[1]) w[15:8] = adq_out[15:8];
      mdl_mem[mdl_addr] = w;
    end
    if (!cs_n && !oe_n)    mdl_tail <= 2;
    else if (mdl_tail > 0) mdl_tail <= mdl_tail - 1;
  end

  // R10: contention monitor, sampled 1 ns after each edge
  always begin
    @(clk); #1;
    if (rst_n && mdl_drv && adq_oe) n_clash++;
  end

  // ---------------- bench reference ----------------
  logic [15:0] ref_mem [logic [17:0]];

  function automatic logic [15:0] ref_word(input logic [17:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  // control snapshot {cs_n,avd_n,oe_n,we_n,adq_oe,req_ready,rd_valid,be_n}
  function automatic logic [8:0] ctl_exp(input bit cs, input bit avd, input bit oe,
      input bit we, input bit drv, input bit rdy, input bit rv, input logic [1:0] be);
    return {cs, avd, oe, we, drv, rdy, rv, be};
  endfunction

  function automatic logic [8:0] ctl_now();
    return {cs_n, avd_n, oe_n, we_n, adq_oe, req_ready, rd_valid, be_n};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_ctl(input string req, input string what, input logic [8:0] e);
    chk(ctl_now() == e, req, what, 32'(ctl_now()), 32'(e));
  endtask

  task automatic chk_addr(input string req, input logic [17:0] a);
    chk({addr_hi, adq_out} == a, req, "address on bus", 32'({addr_hi, adq_out}), 32'(a));
  endtask

  // One access with per-cycle protocol checks. hold_valid keeps req_valid high
  // with a decoy request through the access (R9).
  task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit hold_valid);
    logic [15:0] exp_rd;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    if (hold_valid) begin
      req_write = ~wr; req_addr = ~a; req_wdata = ~d; req_mask = ~m;
    end else req_valid = 1'b0;
    for (int i = 0; i < T_SET; i++) begin
      chk_ctl("R2", "setup controls", ctl_exp(0,1,1,1,1,0,0,2'b11));
      chk_addr("R2", a);
      @(negedge clk);
    end
    for (int i = 0; i < T_AVD; i++) begin
      chk_ctl("R3", "strobe low", ctl_exp(0,0,1,1,1,0,0,2'b11));
      chk_addr("R3", a);
      @(negedge clk);
    end
    for (int i = 0; i < T_AH; i++) begin
      chk_ctl("R3", "address hold", ctl_exp(0,1,1,1,1,0,0,2'b11));
      chk_addr("R3", a);
      @(negedge clk);
    end
    if (!wr) begin
      exp_rd = lanes(ref_word(a), m);
      for (int i = 0; i < T_RD; i++) begin
        chk_ctl("R4", "read data phase", ctl_exp(0,1,0,1,0,0,0,~m));
        @(negedge clk);
      end
      chk(rd_data == exp_rd, "R4", "read word", 32'(rd_data), 32'(exp_rd));
      for (int i = 0; i < T_HZ; i++) begin
        chk_ctl("R7", "turnaround", ctl_exp(1,1,1,1,0,0,(i == 0),2'b11));
        if (i == T_HZ - 1) req_valid = 1'b0;
        @(negedge clk);
      end
    end else begin
      for (int i = 0; i < T_WR; i++) begin
        chk_ctl("R5", "write pulse", ctl_exp(0,1,1,0,1,0,0,~m));
        chk(adq_out == d, "R5", "write data", 32'(adq_out), 32'(d));
        @(negedge clk);
      end
      chk_ctl("R6", "write tail", ctl_exp(1,1,1,1,1,0,0,2'b11));
      chk(adq_out == d, "R6", "data hold", 32'(adq_out), 32'(d));
      req_valid = 1'b0;
      @(negedge clk);
      ref_mem[a] = merge(ref_word(a), d, m);
    end
    chk_ctl("R8", "idle gap between accesses", ctl_exp(1,1,1,1,0,1,0,2'b11));
    if (hold_valid)
      chk(1'b1 && cs_n, "R9", "decoy request not started", 32'(cs_n), 32'(1));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [17:0] pool [8];
    bit pwr_ok;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk_ctl("R1", "reset state", ctl_exp(1,1,1,1,0,0,0,2'b11));
    req_valid = 1'b1; req_addr = 18'h2_5555; // request during power-up (R1)
    rst_n = 1'b1;
    pwr_ok = 1'b1;
    for (int i = 0; i < PWR; i++) begin
      @(negedge clk);
      if (req_ready || !cs_n) pwr_ok = 1'b0;
    end
    req_valid = 1'b0;
    chk(pwr_ok, "R1", "quiet through power-up", 32'(pwr_ok), 32'(1));
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after power-up", 32'(req_ready), 32'(1));
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", "early request not started", 32'(cs_n), 32'(0 + 1));

    // directed corner cases
    access(1, 18'h3_FFFF, 16'hA5C3, 2'b11, 0);
    access(0, 18'h3_FFFF, 16'h0000, 2'b11, 0);
    access(1, 18'h0_0000, 16'h1234, 2'b11, 0);
    access(1, 18'h0_0000, 16'hFF99, 2'b01, 0);   // low byte only
    access(0, 18'h0_0000, 16'h0000, 2'b11, 0);   // expect 1299
    access(1, 18'h0_0000, 16'h77EE, 2'b10, 0);   // high byte only
    access(0, 18'h0_0000, 16'h0000, 2'b01, 0);   // low lane read
    access(1, 18'h0_0000, 16'hDEAD, 2'b00, 0);   // no lanes
    access(0, 18'h0_0000, 16'h0000, 2'b11, 1);   // held valid (R9)
    access(1, 18'h1_8001, 16'hBEEF, 2'b11, 1);   // held valid (R9)
    access(0, 18'h1_8001, 16'h0000, 2'b10, 0);

    // constrained random, back to back, small address pool
    for (int i = 0; i < 8; i++) pool[i] = 18'($urandom);
    for (int i = 0; i < 80; i++) begin
      access(1'($urandom), pool[$urandom % 8], 16'($urandom), 2'($urandom),
             ($urandom % 5) == 0);
    end

    chk(n_clash == 0, "R10", "bus contention samples", 32'(n_clash), 32'(0));
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule